// File: doc/BRIEF.md
# Five-Function Integer ALU

A purely combinational arithmetic logic unit for a 32-bit integer datapath. It takes two operands and a 3-bit operation code and returns a result word together with zero, overflow and carry-out flags. The supported functions are bitwise AND, bitwise OR, addition, subtraction and a signed less-than comparison that produces 0 or 1.

The top bit of the operation code is the negate control. When it is set, operand B is inverted and a carry of one is fed into the least significant bit, which turns the adder into a subtractor. The low two bits pick the per-bit output: the AND term, the OR term, the adder sum, or a "less" input. For the comparison, the "less" input of bit 0 carries the sign of A minus B, corrected for overflow. All other bits of the "less" input are zero. The adder is built from groups of carry-lookahead cells, with a second lookahead level across the groups. Operation codes outside the five listed return a zero result.

Top module: `alu_core`

## Requirements
- R1: Operation code 000 returns the bitwise AND of A and B.
- R2: Operation code 001 returns the bitwise OR of A and B.
- R3: Operation code 010 returns the low 32 bits of A + B.
- R4: Operation code 110 returns the low 32 bits of A + ~B + 1, which equals A - B.
- R5: Operation code 111 returns 1 in bit 0 when A is less than B as signed two's-complement values, and 0 otherwise. Bits 31..1 are always 0, and the answer stays correct when the subtraction overflows (for example minint against a positive value).
- R6: zero_o is 1 exactly when all 32 bits of result_o are 0, for every operation code.
- R7: overflow_o equals signed overflow of the addition for code 010 and of the subtraction for code 110. It is 0 for every other code.
- R8: For every operation code, carry_o is bit 32 of A + (op[2] ? ~B : B) + op[2].
- R9: Operation codes 011, 100 and 101 return a result of 0, so zero_o is 1 for them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_i | input | 3 | Operation code; bit 2 is the negate control, bits 1..0 select the output |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow for add and subtract |
| carry_o | output | 1 | Carry out of the most significant adder bit |

## Verification
The block holds no state, so any fault in the lookahead terms, the negate path or the output select shows up at the ports in the same cycle the operands are applied. A wrong group-level generate or propagate corrupts the sum only for operand pairs whose carries cross group boundaries. For that reason every operation is driven with the corner values 0, 1, -1, maxint and minint in all pairings, and also with random operands. A fault in the overflow correction of the comparison shows up only on overflowing subtractions, which is why minint and maxint are paired against each other and against small values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } res_sel_e;
endpackage

// File: rtl/alu_cla_group.sv
module alu_cla_group #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         gen_o,
  output logic         prop_o
);
  logic [N-1:0] g, p, c;

  assign g = a_i & b_i;
  assign p = a_i ^ b_i;

  // carries in expanded sum-of-products form, no bit-to-bit ripple
  always_comb begin
    c[0] = cin_i;
    for (int i = 1; i < N; i++) begin
      logic acc, run;
      acc = 1'b0;
      run = 1'b1;
      for (int j = i - 1; j >= 0; j--) begin
        acc = acc | (run & g[j]);
        run = run & p[j];
      end
      c[i] = acc | (run & cin_i);
    end
  end

  always_comb begin
    logic acc, run;
    acc = 1'b0;
    run = 1'b1;
    for (int j = N - 1; j >= 0; j--) begin
      acc = acc | (run & g[j]);
      run = run & p[j];
    end
    gen_o  = acc;
    prop_o = run;
  end

  assign sum_o = p ^ c;
endmodule

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GROUP = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_o,
  output logic             cout_o
);
  localparam int unsigned NG = WIDTH / GROUP;

  logic [NG-1:0] gg, gp;
  logic [NG:0]   gc;

  // second lookahead level across groups
  always_comb begin
    gc[0] = cin_i;
    for (int k = 1; k <= NG; k++) begin
      logic acc, run;
      acc = 1'b0;
      run = 1'b1;
      for (int j = k - 1; j >= 0; j--) begin
        acc = acc | (run & gg[j]);
        run = run & gp[j];
      end
      gc[k] = acc | (run & cin_i);
    end
  end

  for (genvar k = 0; k < NG; k++) begin : g_grp
    alu_cla_group #(.N(GROUP)) u_grp (
      .a_i   (a_i[k*GROUP +: GROUP]),
      .b_i   (b_i[k*GROUP +: GROUP]),
      .cin_i (gc[k]),
      .sum_o (sum_o[k*GROUP +: GROUP]),
      .gen_o (gg[k]),
      .prop_o(gp[k])
    );
  end

  assign cout_o  = gc[NG];
  // carry into the MSB recovered from its sum and operand bits
  assign c_msb_o = sum_o[WIDTH-1] ^ a_i[WIDTH-1] ^ b_i[WIDTH-1];

  always_comb begin
    assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("a_r3_adder_sum mismatch");
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] result_i,
  input  logic             sum_msb_i,
  input  logic             c_msb_i,
  input  logic             cout_i,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             less_o
);
  assign zero_o = ~|result_i;
  assign ovf_o  = c_msb_i ^ cout_i;
  // sign corrected by overflow gives the true signed compare
  assign less_o = sum_msb_i ^ ovf_o;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GROUP = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic             carry_o
);
  logic             negate;
  logic [WIDTH-1:0] b_eff, sum, sel_res, less_vec;
  logic             c_msb, cout, ovf_raw, less, op_valid, op_arith;
  res_sel_e         sel;

  assign negate = op_i[2];
  assign sel    = res_sel_e'(op_i[1:0]);
  assign b_eff  = negate ? ~b_i : b_i;

  alu_cla_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_add (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (negate),
    .sum_o  (sum),
    .c_msb_o(c_msb),
    .cout_o (cout)
  );

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .result_i (result_o),
    .sum_msb_i(sum[WIDTH-1]),
    .c_msb_i  (c_msb),
    .cout_i   (cout),
    .zero_o   (zero_o),
    .ovf_o    (ovf_raw),
    .less_o   (less)
  );

  assign less_vec = {{(WIDTH-1){1'b0}}, less};

  always_comb begin
    unique case (sel)
      SEL_AND:  sel_res = a_i & b_eff;
      SEL_OR:   sel_res = a_i | b_eff;
      SEL_SUM:  sel_res = sum;
      SEL_LESS: sel_res = less_vec;
      default:  sel_res = '0;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT: op_valid = 1'b1;
      default:                               op_valid = 1'b0;
    endcase
  end

  assign op_arith   = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign result_o   = op_valid ? sel_res : '0;
  assign overflow_o = op_arith & ovf_raw;
  assign carry_o    = cout;

  always_comb begin
    if (op_i == OP_SUB)
      assert (result_o == a_i - b_i) else $error("a_r4_sub_result");
    if (op_i == OP_SLT)
      assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
        else $error("a_r5_slt_result");
    if (!op_arith)
      assert (!overflow_o) else $error("a_r7_no_overflow");
    if (!op_valid)
      assert (result_o == '0 && zero_o) else $error("a_r9_unused_zero");
  end
endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb;
  localparam int unsigned W = 32;
  localparam time HALF = 2.5ns;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b, res;
  logic [2:0]   op;
  logic         zf, of, cf;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #HALF clk = ~clk;

  alu_core u_dut (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(res), .zero_o(zf), .overflow_o(of), .carry_o(cf)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h op=%b act=%h exp=%h", tag, a, b, op, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic [2:0] top);
    logic [W:0]   ext;
    logic [W-1:0] bb, er;
    logic         neg, sov, eo;
    string        tag;
    @(posedge clk);
    #1;
    a = ta; b = tb; op = top;
    neg = top[2];
    bb  = neg ? ~tb : tb;
    ext = {1'b0, ta} + {1'b0, bb} + {{W{1'b0}}, neg};
    sov = (ta[W-1] == bb[W-1]) && (ext[W-1] != ta[W-1]);
    case (top)
      3'b000: begin er = ta & tb; tag = "R1"; end
      3'b001: begin er = ta | tb; tag = "R2"; end
      3'b010: begin er = ta + tb; tag = "R3"; end
      3'b110: begin er = ta - tb; tag = "R4"; end
      3'b111: begin er = ($signed(ta) < $signed(tb)) ? 32'd1 : 32'd0; tag = "R5"; end
      default: begin er = '0; tag = "R9"; end
    endcase
    eo = (top == 3'b010 || top == 3'b110) ? sov : 1'b0;
    @(negedge clk);
    chk(tag, res, er);
    chk("R6", {31'b0, zf}, {31'b0, (er == '0)});
    chk("R7", {31'b0, of}, {31'b0, eo});
    chk("R8", {31'b0, cf}, {31'b0, ext[W]});
  endtask

  initial begin
    #(200000 * 2 * HALF);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corner [5];
    corner[0] = 32'h0000_0000;
    corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000;
    a = '0; b = '0; op = 3'b000;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state with zero operands
    chk("R1", res, '0);
    chk("R6", {31'b0, zf}, 32'd1);
    chk("R7", {31'b0, of}, 32'd0);
    // R5 overflow-corrected compare: minint < 1, maxint > -1
    apply(32'h8000_0000, 32'h0000_0001, 3'b111);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int o = 0; o < 8; o++)
          apply(corner[i], corner[j], 3'(o));
    for (int n = 0; n < 400; n++)
      for (int o = 0; o < 8; o++)
        apply($urandom, $urandom, 3'(o));
    // R3 carry crossing every lookahead group
    apply(32'h0FFF_FFFF, 32'h0000_0001, 3'b010);
    apply(32'hFFFF_FFF0, 32'h0000_0010, 3'b010);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule